// File: doc/BRIEF.md
# Write-Through Line Cache Bridge

This block is inserted into an existing path between a requester that works in narrow words and a memory controller that works in wide words. Each cache line holds exactly one wide memory word. Reads that hit are answered from the local line store. Reads that miss fetch the whole wide word, place it in a way of the indexed set and return the narrow word that was asked for. Writes always travel on to memory. They update the local copy only when the line is already held.

Both sides use the same handshake. A request is accepted on a clock edge where `req` and `ready` are both high. Read data comes back later with its own one-cycle valid strobe. Requests enter a small buffer whose depth is a parameter. With one slot, the ready signal is a flop output and acceptance drops to one request every two clocks. With two or more slots, a request can be taken on every clock until the buffer fills. Requests are always served in arrival order.

Top module: `wt_line_cache`

## Requirements
- R1: The requester address is {line address, word index}. The low log2(DN_DW/UP_DW) bits form the word index k, which selects bits k*UP_DW .. (k+1)*UP_DW-1 of the wide word. The low bits of the line address select the set, and the remaining bits form the tag.
- R2: A read that hits returns the selected word with `up_rvalid` and issues no memory request.
- R3: A read that misses issues exactly one memory read (`dn_we`=0, `dn_be`=0) for the line address. When `dn_rvalid` arrives, the returned word is written into a way of the set, and the selected narrow word is returned with `up_rvalid` in the following cycle.
- R4: Every write is forwarded as one memory write to the line address. `dn_wdata` carries the narrow word copied into every lane. `dn_be` carries `up_be` in lane k, with all other lanes zero. A mask bit of 1 means the byte is written.
- R5: A write that misses does not allocate: a later read of that line misses.
- R6: A write that hits changes only the masked bytes of the held line, so a later read hit returns the merged word.
- R7: Replacement fills an invalid way first, and otherwise evicts the least recently used way of the set. Both read hits and write hits count as a use.
- R8: Each accepted read produces exactly one `up_rvalid` pulse. Responses come back in acceptance order.
- R9: With REQ_SLOTS of 2 or more, `up_ready` stays high while the buffer has a free slot, so requests are accepted on consecutive clocks.
- R10: With REQ_SLOTS = 1, `up_ready` is a register output and is low in the cycle after any acceptance.
- R11: Reset is synchronous and active high. It clears every valid bit, empties the buffer and drives `up_rvalid` and `dn_req` low, with `up_ready` high afterwards.
- R12: While `dn_req` is high and `dn_ready` is low, the memory request and its address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Requester request valid |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | log2(DN_DW/UP_DW)+DN_AW | Narrow-word address |
| up_wdata | input | UP_DW | Write data |
| up_be | input | UP_DW/8 | Byte write mask, 1 = write byte |
| up_ready | output | 1 | Request accepted when high with up_req |
| up_rvalid | output | 1 | Read data strobe |
| up_rdata | output | UP_DW | Read data |
| dn_req | output | 1 | Memory request valid |
| dn_we | output | 1 | Memory write |
| dn_addr | output | DN_AW | Memory line address |
| dn_wdata | output | DN_DW | Memory write data |
| dn_be | output | DN_DW/8 | Memory byte mask |
| dn_ready | input | 1 | Memory accepts request |
| dn_rvalid | input | 1 | Memory read data strobe |
| dn_rdata | input | DN_DW | Memory read data |

## Verification
On every cycle, the assertions check several properties. The memory request must hold steady while it is stalled. The response strobe must never last longer than one cycle. A memory write mask must never touch more than one lane. Tag lookups must never match two ways. The buffer must never overflow, and with a single slot it must drop ready after each acceptance. Only the bench's scenarios can show the remaining behaviour: that the correct word of a line is returned, the difference between a hit and a miss, the merge of a write hit, the no-allocate rule, the choice of the least recently used victim, and the clearing of contents by reset.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_HITRD,
    ST_MREQ,
    ST_MWAIT
  } wlc_state_e;
endpackage

// File: rtl/wlc_reqbuf.sv
module wlc_reqbuf #(
  parameter int PW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  output logic [PW-1:0] out_data,
  input  logic          out_pop
);
  generate
    if (DEPTH == 1) begin : g_single
      logic [PW-1:0] slot_q;
      logic          full_q;
      logic          rdy_q;
      logic          push;
      logic          full_n;

      assign push   = in_valid && rdy_q;
      assign full_n = push ? 1'b1 : (out_pop ? 1'b0 : full_q);

      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= 1'b0;
          rdy_q  <= 1'b1;
        end else begin
          full_q <= full_n;
          rdy_q  <= !full_n;
        end
        if (push) slot_q <= in_data;
      end

      assign in_ready  = rdy_q;
      assign out_valid = full_q;
      assign out_data  = slot_q;

      AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R10
    end else begin : g_fifo
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(DEPTH + 1);
      logic [PW-1:0]    store [DEPTH];
      logic [PTR_W-1:0] wr_ptr, rd_ptr;
      logic [CNT_W-1:0] cnt_q;
      logic             push;

      assign in_ready  = (cnt_q != CNT_W'(DEPTH));
      assign push      = in_valid && in_ready;
      assign out_valid = (cnt_q != '0);
      assign out_data  = store[rd_ptr];

      always_ff @(posedge clk) begin
        if (rst) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          cnt_q  <= '0;
        end else begin
          if (push)
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
          if (out_pop)
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
          if (push && !out_pop)      cnt_q <= cnt_q + 1'b1;
          else if (!push && out_pop) cnt_q <= cnt_q - 1'b1;
        end
        if (push) store[wr_ptr] <= in_data;
      end

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R9
    end
  endgenerate
endmodule

// File: rtl/wlc_tags.sv
module wlc_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  set_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic                     hit,
  output logic [WAY_W-1:0]         hit_way,
  output logic [WAY_W-1:0]         victim_way,
  input  logic                     touch_en,
  input  logic [WAY_W-1:0]         touch_way,
  input  logic                     fill_en
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  hit_vec;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hit_vec[gw] = vld_q[set_i][gw] && (tag_q[set_i][gw] == tag_i);
    end
  endgenerate

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (!vld_q[set_i][w] && !found) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way)
            age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < age_q[set_i][touch_way])
            age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
      if (fill_en) begin
        vld_q[set_i][touch_way] <= 1'b1;
        tag_q[set_i][touch_way] <= tag_i;
      end
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R3
endmodule

// File: rtl/wlc_data.sv
module wlc_data #(
  parameter int DEPTH = 8,
  parameter int DW    = 128
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [DW/8-1:0]          wr_be
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < DW / 8; b++)
        if (wr_be[b]) ram[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
    if (rd_en) rd_data <= ram[rd_addr];
  end
endmodule

// File: rtl/wt_line_cache.sv
module wt_line_cache #(
  parameter int LINE_COUNT = 8,
  parameter int WAY_COUNT  = 2,
  parameter int UP_DW      = 32,
  parameter int DN_AW      = 8,
  parameter int DN_DW      = 128,
  parameter int REQ_SLOTS  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  up_req,
  input  logic                                  up_we,
  input  logic [$clog2(DN_DW/UP_DW)+DN_AW-1:0]  up_addr,
  input  logic [UP_DW-1:0]                      up_wdata,
  input  logic [UP_DW/8-1:0]                    up_be,
  output logic                                  up_ready,
  output logic                                  up_rvalid,
  output logic [UP_DW-1:0]                      up_rdata,
  output logic                                  dn_req,
  output logic                                  dn_we,
  output logic [DN_AW-1:0]                      dn_addr,
  output logic [DN_DW-1:0]                      dn_wdata,
  output logic [DN_DW/8-1:0]                    dn_be,
  input  logic                                  dn_ready,
  input  logic                                  dn_rvalid,
  input  logic [DN_DW-1:0]                      dn_rdata
);
  import wlc_pkg::*;

  localparam int WPL    = DN_DW / UP_DW;
  localparam int OFS_W  = $clog2(WPL);
  localparam int UP_AW  = OFS_W + DN_AW;
  localparam int UP_BE  = UP_DW / 8;
  localparam int DN_BE  = DN_DW / 8;
  localparam int SETS   = LINE_COUNT / WAY_COUNT;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = DN_AW - SET_W;
  localparam int WAY_W  = (WAY_COUNT > 1) ? $clog2(WAY_COUNT) : 1;
  localparam int IDX_W  = $clog2(LINE_COUNT);
  localparam int PW     = 1 + UP_AW + UP_DW + UP_BE;

  // request buffer
  logic          q_valid, q_pop;
  logic [PW-1:0] q_data;

  wlc_reqbuf #(.PW(PW), .DEPTH(REQ_SLOTS)) u_buf (
    .clk(clk), .rst(rst),
    .in_valid(up_req), .in_ready(up_ready),
    .in_data({up_we, up_addr, up_wdata, up_be}),
    .out_valid(q_valid), .out_data(q_data), .out_pop(q_pop)
  );

  // current request
  wlc_state_e        state_q;
  logic              cur_we;
  logic [UP_AW-1:0]  cur_addr;
  logic [UP_DW-1:0]  cur_wdata;
  logic [UP_BE-1:0]  cur_be;
  logic [DN_AW-1:0]  cur_line;
  logic [OFS_W-1:0]  cur_ofs;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [WAY_W-1:0]  victim_q;

  assign q_pop    = (state_q == ST_IDLE) && q_valid;
  assign cur_line = cur_addr[UP_AW-1:OFS_W];
  assign cur_ofs  = cur_addr[OFS_W-1:0];
  assign cur_set  = cur_line[SET_W-1:0];
  assign cur_tag  = cur_line[DN_AW-1:SET_W];

  // tag store
  logic             lk_hit, fill_go, look_hit;
  logic [WAY_W-1:0] hit_way, victim_way;

  assign look_hit = (state_q == ST_LOOK) && lk_hit;
  assign fill_go  = (state_q == ST_MWAIT) && dn_rvalid;

  wlc_tags #(.SETS(SETS), .WAYS(WAY_COUNT), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .set_i(cur_set), .tag_i(cur_tag),
    .hit(lk_hit), .hit_way(hit_way), .victim_way(victim_way),
    .touch_en(look_hit || fill_go),
    .touch_way(fill_go ? victim_q : hit_way),
    .fill_en(fill_go)
  );

  // lane widening
  logic [DN_DW-1:0] wide_wdata;
  logic [DN_BE-1:0] wide_be;

  always_comb begin
    for (int k = 0; k < WPL; k++) begin
      wide_wdata[k*UP_DW +: UP_DW] = cur_wdata;
      wide_be[k*UP_BE +: UP_BE]    = (OFS_W'(k) == cur_ofs) ? cur_be : '0;
    end
  end

  // line store
  logic             ds_wr;
  logic [IDX_W-1:0] ds_waddr;
  logic [DN_DW-1:0] ds_wdata, ds_rdata;
  logic [DN_BE-1:0] ds_be;

  assign ds_wr    = (look_hit && cur_we) || fill_go;
  assign ds_waddr = fill_go ? {cur_set, victim_q} : {cur_set, hit_way};
  assign ds_wdata = fill_go ? dn_rdata : wide_wdata;
  assign ds_be    = fill_go ? {DN_BE{1'b1}} : wide_be;

  wlc_data #(.DEPTH(LINE_COUNT), .DW(DN_DW)) u_data (
    .clk(clk),
    .rd_en(state_q == ST_LOOK), .rd_addr({cur_set, hit_way}), .rd_data(ds_rdata),
    .wr_en(ds_wr), .wr_addr(ds_waddr), .wr_data(ds_wdata), .wr_be(ds_be)
  );

  // sequencer with registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      up_rvalid <= 1'b0;
      dn_req    <= 1'b0;
      dn_we     <= 1'b0;
    end else begin
      up_rvalid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (q_valid) begin
          {cur_we, cur_addr, cur_wdata, cur_be} <= q_data;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          dn_addr <= cur_line;
          if (cur_we) begin
            dn_req   <= 1'b1;
            dn_we    <= 1'b1;
            dn_wdata <= wide_wdata;
            dn_be    <= wide_be;
            state_q  <= ST_MREQ;
          end else if (lk_hit) begin
            state_q  <= ST_HITRD;
          end else begin
            victim_q <= victim_way;
            dn_req   <= 1'b1;
            dn_we    <= 1'b0;
            dn_be    <= '0;
            state_q  <= ST_MREQ;
          end
        end
        ST_HITRD: begin
          up_rvalid <= 1'b1;
          up_rdata  <= ds_rdata[cur_ofs*UP_DW +: UP_DW];
          state_q   <= ST_IDLE;
        end
        ST_MREQ: if (dn_ready) begin
          dn_req  <= 1'b0;
          state_q <= dn_we ? ST_IDLE : ST_MWAIT;
        end
        ST_MWAIT: if (dn_rvalid) begin
          up_rvalid <= 1'b1;
          up_rdata  <= dn_rdata[cur_ofs*UP_DW +: UP_DW];
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checks on the memory side
  logic [WPL-1:0] lane_any;
  genvar gl;
  generate
    for (gl = 0; gl < WPL; gl++) begin : g_lane
      assign lane_any[gl] = |dn_be[gl*UP_BE +: UP_BE];
    end
  endgenerate

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we))); // R12
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    up_rvalid |=> !up_rvalid); // R8
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_we) |-> ($countones(lane_any) <= 1)); // R4
  AST_READ_NO_MASK: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_we) |-> (lane_any == '0)); // R3
endmodule

// File: tb/wt_line_cache_test.sv
module wt_line_cache_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        up_req = 0, up_we = 0, up_ready, up_rvalid;
  logic [9:0]  up_addr = '0;
  logic [31:0] up_wdata = '0, up_rdata;
  logic [3:0]  up_be = '0;
  logic        dn_req, dn_we, dn_rvalid = 0;
  logic        dn_ready = 1'b1;
  logic [7:0]  dn_addr;
  logic [127:0] dn_wdata, dn_rdata = '0;
  logic [15:0] dn_be;

  wt_line_cache uut (
    .clk(clk), .rst(rst),
    .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_be(up_be), .up_ready(up_ready), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_be(dn_be), .dn_ready(dn_ready), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
  );

  // single-slot instance
  logic        s_req = 0, s_ready, s_rvalid, s_dreq, s_dwe;
  logic [31:0] s_rdata;
  logic [7:0]  s_daddr;
  logic [127:0] s_dwdata;
  logic [15:0] s_dbe;

  wt_line_cache #(.REQ_SLOTS(1)) uut1 (
    .clk(clk), .rst(rst),
    .up_req(s_req), .up_we(1'b1), .up_addr(10'h011), .up_wdata(32'h5),
    .up_be(4'hF), .up_ready(s_ready), .up_rvalid(s_rvalid), .up_rdata(s_rdata),
    .dn_req(s_dreq), .dn_we(s_dwe), .dn_addr(s_daddr), .dn_wdata(s_dwdata),
    .dn_be(s_dbe), .dn_ready(1'b1), .dn_rvalid(1'b0), .dn_rdata(128'h0)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [127:0] mem_arr [256];
  int n_rd = 0, n_wr = 0, pend_cnt = 0;
  logic [7:0]  pend_addr;
  logic [15:0] last_be;
  logic [127:0] last_wdata;

  function automatic logic [31:0] pat(input int a, input int k);
    return 32'hC0DE0000 | (32'(a) << 4) | 32'(k);
  endfunction

  initial
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++) mem_arr[a][k*32 +: 32] = pat(a, k);

  always @(posedge clk) begin
    dn_rvalid <= 1'b0;
    if (pend_cnt != 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) begin
        dn_rvalid <= 1'b1;
        dn_rdata  <= mem_arr[pend_addr];
      end
    end
    if (dn_req && dn_ready && !rst) begin
      if (dn_we) begin
        for (int b = 0; b < 16; b++)
          if (dn_be[b]) mem_arr[dn_addr][b*8 +: 8] = dn_wdata[b*8 +: 8];
        last_be    = dn_be;
        last_wdata = dn_wdata;
        n_wr++;
      end else begin
        pend_addr = dn_addr;
        pend_cnt  = 2;
        n_rd++;
      end
    end
  end

  // response capture
  logic [31:0] resp [64];
  int resp_cnt = 0;
  always @(posedge clk)
    if (up_rvalid && !rst) begin
      if (resp_cnt < 64) resp[resp_cnt] = up_rdata;
      resp_cnt++;
    end

  task automatic send(input bit we, input logic [7:0] m, input logic [1:0] k,
                      input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    up_req = 1; up_we = we; up_addr = {m, k}; up_wdata = d; up_be = be;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_req = 0;
  endtask

  task automatic do_read(input logic [7:0] m, input logic [1:0] k, input bit exp_miss,
                         input string req);
    int c0, r0;
    logic [31:0] exp;
    c0 = resp_cnt; r0 = n_rd;
    exp = mem_arr[m][k*32 +: 32];
    send(1'b0, m, k, 32'h0, 4'h0);
    while (resp_cnt == c0) @(negedge clk);
    chk(resp[c0] == exp, req, 128'(resp[c0]), 128'(exp));
    chk((n_rd - r0) == int'(exp_miss), req, 128'(n_rd - r0), 128'(exp_miss));
  endtask

  task automatic do_write(input logic [7:0] m, input logic [1:0] k,
                          input logic [31:0] d, input logic [3:0] be, input string req);
    int w0, r0;
    w0 = n_wr; r0 = n_rd;
    send(1'b1, m, k, d, be);
    while (n_wr == w0) @(negedge clk);
    chk(last_be == (16'(be) << (4 * k)), req, 128'(last_be), 128'(16'(be) << (4 * k)));
    chk(last_wdata[k*32 +: 32] == d, req, 128'(last_wdata[k*32 +: 32]), 128'(d));
    chk(n_rd == r0, req, 128'(n_rd), 128'(r0));
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  m;
    logic [1:0]  k;
    logic [31:0] d;
    logic [3:0]  be;
    logic        miss;
  } vec_t;

  // sets: line address bits [1:0]; lines 4, 8, 12, 20 share set 0
  localparam vec_t VEC [14] = '{
    '{1'b0, 8'd4,  2'd1, 32'h0,        4'h0, 1'b1},
    '{1'b0, 8'd4,  2'd3, 32'h0,        4'h0, 1'b0},
    '{1'b0, 8'd8,  2'd0, 32'h0,        4'h0, 1'b1},
    '{1'b0, 8'd4,  2'd2, 32'h0,        4'h0, 1'b0},
    '{1'b0, 8'd12, 2'd0, 32'h0,        4'h0, 1'b1},
    '{1'b0, 8'd4,  2'd0, 32'h0,        4'h0, 1'b0},
    '{1'b0, 8'd8,  2'd1, 32'h0,        4'h0, 1'b1},
    '{1'b1, 8'd4,  2'd1, 32'h11223344, 4'h5, 1'b0},
    '{1'b0, 8'd4,  2'd1, 32'h0,        4'h0, 1'b0},
    '{1'b1, 8'd20, 2'd2, 32'hCAFEF00D, 4'hF, 1'b0},
    '{1'b0, 8'd20, 2'd2, 32'h0,        4'h0, 1'b1},
    '{1'b0, 8'd4,  2'd0, 32'h0,        4'h0, 1'b0},
    '{1'b0, 8'd5,  2'd3, 32'h0,        4'h0, 1'b1},
    '{1'b0, 8'd8,  2'd1, 32'h0,        4'h0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:  return "R3 first fill";
      1:  return "R2 hit other word R1";
      4:  return "R7 evict least recent";
      6:  return "R7 evicted line misses";
      7:  return "R4 write hit forwarded";
      8:  return "R6 merged bytes";
      9:  return "R4 write miss forwarded";
      10: return "R5 no allocate";
      11: return "R7 write hit counts as use";
      12: return "R3 other set R1";
      13: return "R7 victim after write use";
      default: return "R2 R3 table read";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8 watchdog", 128'(resp_cnt), 128'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(up_ready == 1'b1, "R11 ready after reset", 128'(up_ready), 128'(1));
    chk(up_rvalid == 1'b0, "R11 rvalid after reset", 128'(up_rvalid), 128'(0));
    chk(dn_req == 1'b0, "R11 dn_req after reset", 128'(dn_req), 128'(0));

    for (int i = 0; i < 14; i++) begin
      if (VEC[i].we) do_write(VEC[i].m, VEC[i].k, VEC[i].d, VEC[i].be, vec_tag(i));
      else           do_read(VEC[i].m, VEC[i].k, VEC[i].miss, vec_tag(i));
      repeat (2) @(negedge clk);
    end

    // R11: reset clears valid bits, line 5 was cached
    do_read(8'd5, 2'd0, 1'b0, "R2 line held before reset");
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    do_read(8'd5, 2'd0, 1'b1, "R11 valid cleared by reset");

    // R9 and R8: back-to-back acceptance, in-order return
    begin
      int c0;
      logic [31:0] ea, eb;
      c0 = resp_cnt;
      ea = mem_arr[5][2*32 +: 32];
      eb = mem_arr[9][1*32 +: 32];
      @(negedge clk);
      up_req = 1; up_we = 0; up_addr = {8'd5, 2'd2};
      chk(up_ready == 1'b1, "R9 ready first", 128'(up_ready), 128'(1));
      @(negedge clk);
      up_addr = {8'd9, 2'd1};
      chk(up_ready == 1'b1, "R9 ready second cycle", 128'(up_ready), 128'(1));
      @(negedge clk);
      up_req = 0;
      while (resp_cnt < c0 + 2) @(negedge clk);
      chk(resp[c0] == ea, "R8 first response", 128'(resp[c0]), 128'(ea));
      chk(resp[c0+1] == eb, "R8 second response", 128'(resp[c0+1]), 128'(eb));
    end

    // R12: stalled memory request holds
    begin
      dn_ready = 0;
      @(negedge clk);
      up_req = 1; up_we = 0; up_addr = {8'd33, 2'd0};
      @(negedge clk);
      up_req = 0;
      repeat (4) @(negedge clk);
      chk(dn_req == 1'b1, "R12 request held", 128'(dn_req), 128'(1));
      chk(dn_addr == 8'd33, "R12 address held", 128'(dn_addr), 128'(33));
      repeat (3) @(negedge clk);
      chk(dn_req == 1'b1 && dn_addr == 8'd33, "R12 still held", 128'(dn_addr), 128'(33));
      dn_ready = 1;
      repeat (10) @(negedge clk);
      chk(resp[resp_cnt-1] == mem_arr[33][31:0], "R3 after stall",
          128'(resp[resp_cnt-1]), 128'(mem_arr[33][31:0]));
    end

    // R10: single slot drops ready after acceptance
    @(negedge clk);
    chk(s_ready == 1'b1, "R10 single slot ready idle", 128'(s_ready), 128'(1));
    s_req = 1;
    @(negedge clk);
    s_req = 0;
    chk(s_ready == 1'b0, "R10 ready low after accept", 128'(s_ready), 128'(0));
    repeat (8) @(negedge clk);
    chk(s_ready == 1'b1, "R10 ready back", 128'(s_ready), 128'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule